// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the slave side of a three-wire serial EEPROM port with chip select, serial clock, data in and data out, in front of a 2048-byte register-file array. A host raises chip select and clocks in a start bit. It then sends a two-bit opcode and an address. A write also carries a data word. The block then reads the array, programs it, or changes its write-enable latch.

Programming runs as a self-timed cycle counted in system clocks. It needs no serial clock activity. While chip select is high, data out reports ready/busy. An organization input picks 8-bit or 16-bit words. A program-enable input gates every change to the array. The serial inputs are sampled in the system clock domain, and a rising serial clock edge is seen as a change of the sampled clock from low to high.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While cs_i is low, the front end is held idle, any partial instruction is discarded and do_o is low; a cs_i drop in the middle of a write frame leaves the array unchanged.
- R2: With cs_i high and no start bit yet, rising sk_i edges that sample di_i low change nothing; the first rising edge that samples di_i high is the start bit.
- R3: After the start bit, bits are taken MSB first on rising sk_i edges: 2 opcode bits, then 11 address bits when org_i is low (x8) or 10 when high (x16), then 8 or 16 data bits for writes. Opcodes are 10 read, 01 write, 11 erase, and 00 special, in which the two top address bits pick 11 enable, 00 disable, 10 erase all, 01 write all.
- R4: On a read, the rising edge that takes the last address bit drives do_o to a dummy 0, and each following rising edge presents the next data bit, MSB first.
- R5: A read with cs_i held high streams successive words, with the address incrementing and wrapping from the last word to word 0.
- R6: The write-enable latch is clear after reset; write, erase, erase-all and write-all are ignored while it is clear; the enable code sets it and the disable code clears it.
- R7: With pe_i low when an instruction completes, no erase or write takes place and the array stays unchanged.
- R8: An accepted write or erase starts a self-timed busy cycle of PROG_CYCLES system clocks with no sk_i activity needed; the array takes the new value when the cycle ends.
- R9: Erase sets the addressed word to all ones.
- R10: Erase all sets every byte to 8'hFF; write all stores the data word into every word.
- R11: After an accepted erase or write, with cs_i high, do_o is low while busy and high once ready; this status stays on do_o until cs_i goes low, and start bits are not taken while busy.
- R12: A busy cycle that has begun completes and updates the array even if cs_i falls before it ends.
- R13: After a complete non-read instruction, further sk_i and di_i activity is ignored until cs_i goes low.
- R14: In x16 mode, word n occupies bytes 2n (high) and 2n+1 (low) of the byte array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled by clk_i |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word size: 1 = 16-bit, 0 = 8-bit |
| pe_i | input | 1 | Program enable, active high |
| do_o | output | 1 | Serial data out and ready/busy status |

## Verification
The assertions assume that cs_i, sk_i and di_i are synchronous to clk_i. They also assume that each sk_i level lasts at least one system clock, so that every rising serial edge is seen exactly once. The bench changes all serial inputs on the falling system clock edge. It holds each sk_i level for two system clocks and keeps org_i constant within a selected frame. This keeps every serial edge clean for the edge detector. The busy-length check in the checker counts busy clocks itself, so the window does not depend on unrolled delays.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_WRITE, CMD_ERASE, CMD_WRAL, CMD_ERAL, CMD_EWEN, CMD_EWDS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } fe_state_e;

  function automatic logic is_prog(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRAL) || (c == CMD_ERAL);
  endfunction
endpackage

// File: rtl/mw_array.sv
module mw_array import mw_pkg::*; #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              org_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_word_o,
  input  logic              wr_en_i,
  input  cmd_e              wr_cmd_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              wr_org_i
);
  localparam int Bytes = 1 << ADDR_W;

  logic [7:0] mem_q [Bytes];

  logic [ADDR_W-1:0] rd_hi, rd_lo, wr_hi, wr_lo;
  assign rd_hi = {rd_addr_i[ADDR_W-2:0], 1'b0};
  assign rd_lo = {rd_addr_i[ADDR_W-2:0], 1'b1};
  assign wr_hi = {wr_addr_i[ADDR_W-2:0], 1'b0};
  assign wr_lo = {wr_addr_i[ADDR_W-2:0], 1'b1};

  // read word left aligned: x8 byte sits in [15:8]
  always_comb begin
    if (org_i) rd_word_o = {mem_q[rd_hi], mem_q[rd_lo]};
    else       rd_word_o = {mem_q[rd_addr_i], 8'h00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Bytes; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en_i) begin
      unique case (wr_cmd_i)
        CMD_WRITE, CMD_ERASE: begin
          if (wr_org_i) begin
            mem_q[wr_hi] <= (wr_cmd_i == CMD_ERASE) ? 8'hFF : wr_data_i[15:8];
            mem_q[wr_lo] <= (wr_cmd_i == CMD_ERASE) ? 8'hFF : wr_data_i[7:0];
          end else begin
            mem_q[wr_addr_i] <= (wr_cmd_i == CMD_ERASE) ? 8'hFF : wr_data_i[7:0];
          end
        end
        CMD_ERAL: for (int i = 0; i < Bytes; i++) mem_q[i] <= 8'hFF;
        CMD_WRAL: for (int i = 0; i < Bytes; i++)
          mem_q[i] <= (!wr_org_i || i[0]) ? wr_data_i[7:0] : wr_data_i[15:8];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_front.sv
module mw_front import mw_pkg::*; #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  logic              di_i,
  input  logic              org_i,
  input  logic              busy_i,
  input  logic [15:0]       rd_word_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              do_o,
  output logic              start_o,
  output logic              idle_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o
);
  localparam int CntW = 5;
  localparam logic [ADDR_W-1:0] MaskX16 = {1'b0, {(ADDR_W-1){1'b1}}};

  fe_state_e         st_q;
  logic [CntW-1:0]   cnt_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q, addr_nx, addr_sel, addr_inc;
  logic [15:0]       data_q, sh_q;
  logic              do_q;
  logic [CntW-1:0]   aw_m1, dw_m1;
  logic [1:0]        sub;
  cmd_e              cmd;
  logic              last_addr, last_data;

  assign aw_m1   = org_i ? CntW'(ADDR_W - 2) : CntW'(ADDR_W - 1);
  assign dw_m1   = org_i ? CntW'(15) : CntW'(7);
  assign addr_nx = {addr_q[ADDR_W-2:0], di_i};
  assign addr_sel = (st_q == ST_ADDR) ? addr_nx : addr_q;
  assign addr_inc = org_i ? ((addr_q + 1'b1) & MaskX16) : (addr_q + 1'b1);
  assign sub     = org_i ? addr_sel[ADDR_W-2 -: 2] : addr_sel[ADDR_W-1 -: 2];

  always_comb begin
    unique case (op_q)
      2'b01:   cmd = CMD_WRITE;
      2'b11:   cmd = CMD_ERASE;
      2'b10:   cmd = CMD_NONE;
      default: begin
        unique case (sub)
          2'b11:   cmd = CMD_EWEN;
          2'b10:   cmd = CMD_ERAL;
          2'b01:   cmd = CMD_WRAL;
          default: cmd = CMD_EWDS;
        endcase
      end
    endcase
  end

  assign last_addr   = sk_rise_i && (st_q == ST_ADDR) && (cnt_q == '0);
  assign last_data   = sk_rise_i && (st_q == ST_DATA) && (cnt_q == '0);
  assign start_o     = sk_rise_i && (st_q == ST_IDLE) && di_i && !busy_i;
  assign cmd_valid_o = last_data ||
                       (last_addr && cmd != CMD_NONE && cmd != CMD_WRITE && cmd != CMD_WRAL);
  assign cmd_o       = cmd;
  assign addr_o      = addr_sel;
  assign data_o      = {data_q[14:0], di_i};
  assign rd_addr_o   = addr_q;
  assign do_o        = do_q;
  assign idle_o      = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; op_q <= '0;
      addr_q <= '0; data_q <= '0; sh_q <= '0; do_q <= 1'b0;
    end else if (!cs_i) begin
      st_q <= ST_IDLE; cnt_q <= '0; do_q <= 1'b0;
    end else if (sk_rise_i) begin
      unique case (st_q)
        ST_IDLE: if (start_o) begin
          st_q <= ST_OPC; cnt_q <= CntW'(1);
          addr_q <= '0; data_q <= '0;
        end
        ST_OPC: begin
          op_q <= {op_q[0], di_i};
          if (cnt_q == '0) begin st_q <= ST_ADDR; cnt_q <= aw_m1; end
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_ADDR: begin
          addr_q <= addr_nx;
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (cmd == CMD_NONE) begin
            st_q <= ST_READ; cnt_q <= '0; do_q <= 1'b0;  // dummy bit
          end else if (cmd == CMD_WRITE || cmd == CMD_WRAL) begin
            st_q <= ST_DATA; cnt_q <= dw_m1;
          end else st_q <= ST_DONE;
        end
        ST_DATA: begin
          data_q <= data_o;
          if (cnt_q == '0) st_q <= ST_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_READ: begin
          if (cnt_q == '0) begin
            do_q <= rd_word_i[15]; sh_q <= {rd_word_i[14:0], 1'b0};
            cnt_q <= dw_m1; addr_q <= addr_inc;
          end else begin
            do_q <= sh_q[15]; sh_q <= {sh_q[14:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;  // ST_DONE: wait for deselect
      endcase
    end
  end
endmodule

// File: rtl/mw_prog.sv
module mw_prog import mw_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              org_i,
  input  logic              pe_i,
  output logic              ewen_o,
  output logic              busy_o,
  output logic              start_o,
  output logic              commit_o,
  output cmd_e              p_cmd_o,
  output logic [ADDR_W-1:0] p_addr_o,
  output logic [15:0]       p_data_o,
  output logic              p_org_o
);
  localparam int CntW = $clog2(PROG_CYCLES + 1);

  logic [CntW-1:0] cnt_q;
  logic            ewen_q;

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CntW'(1));
  assign start_o  = cmd_valid_i && is_prog(cmd_i) && ewen_q && pe_i && !busy_o;
  assign ewen_o   = ewen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ewen_q <= 1'b0; cnt_q <= '0;
      p_cmd_o <= CMD_NONE; p_addr_o <= '0; p_data_o <= '0; p_org_o <= 1'b0;
    end else begin
      if (cmd_valid_i && cmd_i == CMD_EWEN) ewen_q <= 1'b1;
      if (cmd_valid_i && cmd_i == CMD_EWDS) ewen_q <= 1'b0;
      if (start_o) begin
        cnt_q <= CntW'(PROG_CYCLES);
        p_cmd_o <= cmd_i; p_addr_o <= addr_i; p_data_o <= data_i; p_org_o <= org_i;
      end else if (busy_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl import mw_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o
);
  logic              sk_q, sk_rise, status_q;
  logic              fe_do, fe_start, fe_idle, cmd_valid;
  cmd_e              cmd, p_cmd;
  logic [ADDR_W-1:0] cmd_addr, rd_addr, p_addr;
  logic [15:0]       cmd_data, rd_word, p_data;
  logic              ewen, busy, prog_start, commit, p_org;

  assign sk_rise = cs_i && sk_i && !sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0; status_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      if (!cs_i || fe_start) status_q <= 1'b0;
      else if (prog_start)   status_q <= 1'b1;
    end
  end

  assign do_o = (status_q && cs_i) ? !busy : fe_do;

  mw_front #(.ADDR_W(ADDR_W)) u_front (
    .clk_i, .rst_ni, .cs_i, .sk_rise_i(sk_rise), .di_i, .org_i,
    .busy_i(busy), .rd_word_i(rd_word), .rd_addr_o(rd_addr), .do_o(fe_do),
    .start_o(fe_start), .idle_o(fe_idle), .cmd_valid_o(cmd_valid),
    .cmd_o(cmd), .addr_o(cmd_addr), .data_o(cmd_data)
  );

  mw_prog #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i, .rst_ni, .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(cmd_addr),
    .data_i(cmd_data), .org_i, .pe_i, .ewen_o(ewen), .busy_o(busy),
    .start_o(prog_start), .commit_o(commit), .p_cmd_o(p_cmd),
    .p_addr_o(p_addr), .p_data_o(p_data), .p_org_o(p_org)
  );

  mw_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .org_i, .rd_addr_i(rd_addr), .rd_word_o(rd_word),
    .wr_en_i(commit), .wr_cmd_i(p_cmd), .wr_addr_i(p_addr),
    .wr_data_i(p_data), .wr_org_i(p_org)
  );
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
  parameter int PROG_CYCLES = 500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic pe_i,
  input logic do_o,
  input logic fe_idle,
  input logic busy,
  input logic ewen,
  input logic prog_start,
  input logic status_q
);
  int unsigned bcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= 0;
    else         bcnt <= busy ? bcnt + 1 : 0;
  end

  a_r1_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> fe_idle);

  // R6 and R7: programming starts only with latch set and pe high
  a_r7_pe_ewen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> (pe_i && ewen));

  a_r8_cycle_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> bcnt == PROG_CYCLES);

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> !busy);

  a_r11_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && fe_idle) |=> fe_idle);

  a_r11_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && status_q && cs_i) |-> !do_o);

  a_r11_ready_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && status_q && cs_i) |-> do_o);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i, .rst_ni, .cs_i, .pe_i, .do_o, .fe_idle, .busy, .ewen,
  .prog_start, .status_q
);

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
  localparam int P = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0, pe = 1'b1;
  logic do_w;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0]  model [2048];
  logic [15:0] exp_q [$];

  always #4 clk = ~clk;

  mw_eeprom_ctrl #(.ADDR_W(11), .PROG_CYCLES(P)) dut (
    .clk_i(clk), .rst_ni, .cs_i(cs), .sk_i(sk), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(do_w)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic q);
    @(negedge clk); sk = 1'b0; di = b;
    @(negedge clk); sk = 1'b1;
    @(negedge clk); @(negedge clk); q = do_w;
  endtask

  task automatic sbits(input logic [15:0] v, input int n, output logic q);
    for (int i = n - 1; i >= 0; i--) sbit(v[i], q);
  endtask

  task automatic sel();   @(negedge clk); cs = 1'b1; sk = 1'b0; @(negedge clk); endtask
  task automatic desel(); @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0; repeat (2) @(negedge clk); endtask

  function automatic int aw(); return org ? 10 : 11; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  // frame: start, opcode, address
  task automatic hdr(input logic [1:0] op, input logic [10:0] a, output logic q);
    sbit(1'b1, q); sbits({14'd0, op}, 2, q); sbits({5'd0, a}, aw(), q);
  endtask

  task automatic special(input logic [1:0] code);
    logic q;
    logic [10:0] a;
    a = org ? {1'b0, code, 8'd0} : {code, 9'd0};
    sel(); hdr(2'b00, a, q); desel();
  endtask

  function automatic logic [15:0] mword(input logic [10:0] a);
    if (org) return {model[{a[9:0], 1'b0}], model[{a[9:0], 1'b1}]};
    return {8'h00, model[a]};
  endfunction

  task automatic mput(input logic [10:0] a, input logic [15:0] d);
    if (org) begin model[{a[9:0], 1'b0}] = d[15:8]; model[{a[9:0], 1'b1}] = d[7:0]; end
    else model[a] = d[7:0];
  endtask

  task automatic wait_ready(input string req);
    int c = 0;
    while (do_w !== 1'b1 && c < 4 * P) begin @(negedge clk); c++; end
    check({req, " ready"}, do_w, 1'b1);
    check({req, " busy length"}, (c >= P - 4 && c <= P) ? 1 : 0, 1);
  endtask

  // write/erase/wral frame; accepted says a busy cycle is expected
  task automatic prog(input logic [1:0] op, input logic [10:0] a, input logic [15:0] d,
                      input bit with_data, input bit accepted, input string req);
    logic q;
    sel(); hdr(op, a, q);
    if (with_data) sbits(d, dw(), q);
    check({req, " status after frame"}, do_w, 1'b0);
    if (accepted) wait_ready(req);
    else begin repeat (P + 4) @(negedge clk); check({req, " no status"}, do_w, 1'b0); end
    desel();
  endtask

  // driver pushes expected words, monitor pops and compares
  task automatic rd(input logic [10:0] a, input int n, input string req);
    logic q;
    logic [15:0] obs;
    logic [10:0] aa = a;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mword(aa));
      aa = org ? {1'b0, aa[9:0] + 10'd1} : aa + 11'd1;
    end
    sel(); hdr(2'b10, a, q);
    check({req, " dummy bit"}, q, 1'b0);
    for (int k = 0; k < n; k++) begin
      obs = '0;
      for (int b = 0; b < dw(); b++) begin sbit(1'b0, q); obs = {obs[14:0], q}; end
      check(req, obs, exp_q.pop_front());
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic q;
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset do_o", do_w, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R6: latch clear after reset, write ignored
    prog(2'b01, 11'd5, 16'h00A5, 1, 0, "R6 write without enable");
    rd(11'd5, 1, "R6 unchanged");

    // R2: zero-bit clocks before start, then enable code
    sel();
    for (int i = 0; i < 5; i++) sbit(1'b0, q);
    check("R2 idle clocks do_o", q, 1'b0);
    hdr(2'b00, 11'b11000000000, q);
    desel();

    // R8/R3 x8 write then R4 read
    prog(2'b01, 11'd5, 16'h00A5, 1, 1, "R8 write x8"); mput(11'd5, 16'h00A5);
    rd(11'd5, 1, "R4 read x8");

    // R14 x16 layout
    org = 1'b1;
    prog(2'b01, 11'd3, 16'h1234, 1, 1, "R14 write x16"); mput(11'd3, 16'h1234);
    rd(11'd3, 1, "R14 read x16");
    org = 1'b0;
    rd(11'd6, 2, "R14 byte view");

    // R5 sequential read with wrap
    prog(2'b01, 11'd2047, 16'h005A, 1, 1, "R5 prep"); mput(11'd2047, 16'h005A);
    prog(2'b01, 11'd0, 16'h00C3, 1, 1, "R5 prep0"); mput(11'd0, 16'h00C3);
    rd(11'd2046, 4, "R5 seq wrap x8");

    // R9 erase
    prog(2'b11, 11'd5, 16'h0, 0, 1, "R9 erase"); mput(11'd5, 16'h00FF);
    rd(11'd5, 1, "R9 erased");

    // R7 program enable low
    pe = 1'b0;
    prog(2'b01, 11'd9, 16'h0011, 1, 0, "R7 pe low");
    pe = 1'b1;
    rd(11'd9, 1, "R7 unchanged");

    // R12 cs drop mid-cycle
    sel(); hdr(2'b01, 11'd12, q); sbits(16'h0077, 8, q);
    repeat (3) @(negedge clk);
    desel(); mput(11'd12, 16'h0077);
    repeat (P + 4) @(negedge clk);
    rd(11'd12, 1, "R12 completed after deselect");

    // R1 abort mid data
    sel(); hdr(2'b01, 11'd20, q); sbits(16'h000F, 4, q);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 do_o deselected", do_w, 1'b0);
    desel();
    repeat (P + 4) @(negedge clk);
    rd(11'd20, 1, "R1 aborted frame");

    // R13 clocks after complete instruction ignored
    sel(); hdr(2'b00, 11'b11000000000, q);
    sbit(1'b1, q); sbits(16'h0001, 2, q); sbits(16'd21, 11, q); sbits(16'h0066, 8, q);
    check("R13 no status", q, 1'b0);
    desel();
    repeat (P + 4) @(negedge clk);
    rd(11'd21, 1, "R13 array untouched");

    // R11 status persists, then clears on deselect
    sel(); hdr(2'b01, 11'd30, q); sbits(16'h0044, 8, q); mput(11'd30, 16'h0044);
    wait_ready("R11");
    sbit(1'b1, q);
    check("R11 status held over clocks", q, 1'b1);
    desel(); sel();
    check("R11 status cleared", do_w, 1'b0);
    desel();
    rd(11'd30, 1, "R11 data");

    // R10 write all / erase all
    prog(2'b00, 11'b01000000000, 16'h003C, 1, 1, "R10 wral");
    for (int i = 0; i < 2048; i++) model[i] = 8'h3C;
    rd(11'd100, 2, "R10 wral read");
    prog(2'b00, 11'b10000000000, 16'h0, 0, 1, "R10 eral");
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    rd(11'd1500, 2, "R10 eral read");

    // R6 disable then write ignored
    special(2'b00);
    prog(2'b01, 11'd40, 16'h0099, 1, 0, "R6 disabled write");
    rd(11'd40, 1, "R6 disabled unchanged");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule